// File: doc/BRIEF.md
# Event-Reloaded Watchdog Timer

This block is a down-counting watchdog. Software stores a start value in a reload register. The counter then counts down by one on each strobe from an external tick source. When the count falls to zero, the counter halts and a sticky time-out flag is raised. Three outside activities can restart the countdown from the stored value and clear the flag. Each one has its own enable bit. The three activities are a keyboard interrupt pulse, a mouse interrupt pulse, and an I/O cycle that hits the fixed game-port address 0x201.

A flat host register interface gives access to the reload value, a control register, a configuration register and the live count. The control register holds the time-out flag, which software may set or clear at any time. It also holds a force bit that clears itself: writing it empties the counter and raises the flag at once. The configuration register holds the three event enables and an interrupt channel number. The block only stores the channel number. A non-zero channel means the interrupt is mapped, and while it is mapped the interrupt output follows the time-out flag.

Top module: `evwdt_top`

## Requirements
- R1: After a synchronous active-low reset, all four registers (reload at offset 0, control at 1, configuration at 2, count at 3) read zero, and both the status output and the interrupt output are low.
- R2: On a cycle with `tick` high, a non-zero count drops by one, unless a load, force or enabled event happens in the same cycle.
- R3: When a tick takes the count from 1 to 0, the time-out flag (control bit 0) is set. A count of zero stays at zero on later ticks.
- R4: A host write to the reload register (offset 0) stores the value and loads it into the counter on the same clock edge.
- R5: A keyboard pulse (enable: configuration bit 0) or a mouse pulse (enable: configuration bit 1) reloads the counter from the stored value and clears the time-out flag, when that event is enabled.
- R6: An event pulse whose enable bit is 0 leaves both the count and the time-out flag unchanged.
- R7: An I/O strobe with address exactly 0x201 counts as the third event (enable: configuration bit 2). A strobe at any other address has no effect.
- R8: A host write to the control register sets the time-out flag to write-data bit 0, whatever the counter is doing.
- R9: Writing 1 to control bit 2 sets the count to zero and sets the time-out flag. Bit 2 always reads back as 0.
- R10: The interrupt output equals the time-out flag while the channel field (configuration bits 7:4) is non-zero, and is low while that field is zero. The field reads back as written.
- R11: On the same edge, a control write decides the flag ahead of an event, and a reload-register write decides the count ahead of an event.
- R12: A stored value of zero never starts a countdown: ticks then leave the count at zero and do not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-down strobe, one clock wide |
| ev_kbd | input | 1 | Keyboard interrupt pulse |
| ev_mouse | input | 1 | Mouse interrupt pulse |
| io_stb | input | 1 | I/O read or write cycle strobe |
| io_addr | input | 16 | Address of the I/O cycle |
| hst_wr | input | 1 | Host register write strobe |
| hst_addr | input | 2 | Host register offset |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data for `hst_addr` (combinational) |
| wdt_status | output | 1 | Time-out flag |
| wdt_irq | output | 1 | Interrupt request, follows the flag while mapped |

## Verification
Directed sequences cover each condition on its own. They show the difference between a natural expiry and a forced one, an enabled event and a disabled one, the game-port address and a nearby address, and a mapped channel and an unmapped one. Dedicated cases put a host write and an event on the same edge, to pin down which one wins for the count and for the flag, and a zero reload value that must never expire. A long random stretch then mixes ticks, all three events, stray I/O addresses and host writes to every offset. These collisions separate the priority order from the decrement and expiry paths. After every cycle all four registers and the interrupt output are compared with a reference model in the bench.

// File: rtl/evwdt_pkg.sv
// Package: shared register offsets, bit positions and the host command
// type for the event-reloaded watchdog.
// Assumes the data path is at least 8 bits wide.
package evwdt_pkg;
    // Register offsets in the flat host map
    localparam int REG_RELOAD = 0;
    localparam int REG_CTRL   = 1;
    localparam int REG_CFG    = 2;
    localparam int REG_COUNT  = 3;

    // Control register bits
    localparam int CTRL_STAT  = 0;
    localparam int CTRL_FORCE = 2;

    // Configuration register: event enables at bits 0..2, channel from bit 4
    localparam int NUM_EV   = 3;
    localparam int CHAN_LSB = 4;

    // Decoded host write command, consumed by the counter
    typedef struct packed {
        logic ld;       // reload register write
        logic ctrl_wr;  // control register write
        logic force_to; // control write with the force bit set
        logic stat_wv;  // value the flag takes on a control write
    } wr_cmd_t;
endpackage

// File: rtl/evwdt_regs.sv
// Module: host register file. Holds the reload value, the event enables
// and the channel number, decodes writes into a command for the counter,
// and muxes the read data.
// Assumes single-cycle writes and combinational reads.
module evwdt_regs
    import evwdt_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int CHAN_W = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              status,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  reload_val,
    output logic [NUM_EV-1:0] ev_en,
    output logic [CHAN_W-1:0] chan,
    output wr_cmd_t           cmd,
    output logic [DATA_W-1:0] rdata
);
    logic sel_reload, sel_ctrl, sel_cfg, sel_count;

    // Address decode
    always_comb begin
        sel_reload = (addr == ADDR_W'(REG_RELOAD));
        sel_ctrl   = (addr == ADDR_W'(REG_CTRL));
        sel_cfg    = (addr == ADDR_W'(REG_CFG));
        sel_count  = (addr == ADDR_W'(REG_COUNT));
    end

    // Write command for the counter
    always_comb begin
        cmd.ld       = wr && sel_reload;
        cmd.ctrl_wr  = wr && sel_ctrl;
        cmd.force_to = wr && sel_ctrl && wdata[CTRL_FORCE];
        cmd.stat_wv  = wdata[CTRL_STAT] | wdata[CTRL_FORCE];
    end

    // Reload value storage
    always_ff @(posedge clk) begin
        if (!rst_n)          reload_val <= '0;
        else if (cmd.ld)     reload_val <= wdata[CNT_W-1:0];
    end

    // Configuration storage: enables and channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_en <= '0;
            chan  <= '0;
        end else if (wr && sel_cfg) begin
            ev_en <= wdata[NUM_EV-1:0];
            chan  <= wdata[CHAN_LSB +: CHAN_W];
        end
    end

    // Read mux; the force bit always reads as zero
    always_comb begin
        rdata = '0;
        if (sel_reload)     rdata[CNT_W-1:0] = reload_val;
        else if (sel_ctrl)  rdata[CTRL_STAT] = status;
        else if (sel_cfg) begin
            rdata[NUM_EV-1:0]          = ev_en;
            rdata[CHAN_LSB +: CHAN_W]  = chan;
        end
        else if (sel_count) rdata[CNT_W-1:0] = count;
    end

    // R9: the force bit is never visible on a control read
    a_r9_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ctrl |-> !rdata[CTRL_FORCE]);
endmodule

// File: rtl/evwdt_event.sv
// Module: reload-event qualifier. Turns the keyboard pulse, the mouse
// pulse and an I/O cycle at the game-port address into one reload hit,
// each gated by its own enable.
// Assumes all pulses are synchronous and one clock wide.
module evwdt_event
    import evwdt_pkg::*;
#(
    parameter int          IOA_W    = 16,
    parameter logic [15:0] JOY_ADDR = 16'h0201
) (
    input  logic              kbd,
    input  logic              mouse,
    input  logic              io_stb,
    input  logic [IOA_W-1:0]  io_addr,
    input  logic [NUM_EV-1:0] en,
    output logic              hit
);
    logic [NUM_EV-1:0] src;
    logic [NUM_EV-1:0] gated;

    // Raw event sources in enable-bit order
    always_comb src = {io_stb && (io_addr == IOA_W'(JOY_ADDR)), mouse, kbd};

    // One enable gate per source
    for (genvar i = 0; i < NUM_EV; i++) begin : g_gate
        assign gated[i] = src[i] & en[i];
    end

    assign hit = |gated;
endmodule

// File: rtl/evwdt_counter.sv
// Module: down-counter and sticky time-out flag.
// The count priority is load, then force, then event reload, then tick.
// The flag priority is control write, then event clear, then expiry.
// Assumes tick is a one-clock strobe.
module evwdt_counter
    import evwdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hit,
    input  wr_cmd_t          cmd,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             status
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic running, expire;

    // Decrement and expiry qualifiers
    always_comb begin
        running = tick && (count != '0) && !cmd.ld && !cmd.force_to && !hit;
        expire  = running && (count == ONE);
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n)            count <= '0;
        else if (cmd.ld)       count <= ld_val;
        else if (cmd.force_to) count <= '0;
        else if (hit)          count <= reload_val;
        else if (running)      count <= count - ONE;
    end

    // Sticky time-out flag
    always_ff @(posedge clk) begin
        if (!rst_n)           status <= 1'b0;
        else if (cmd.ctrl_wr) status <= cmd.stat_wv;
        else if (hit)         status <= 1'b0;
        else if (expire)      status <= 1'b1;
    end

    // R2: a plain tick on a non-zero count decrements it
    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != '0 && !cmd.ld && !cmd.force_to && !hit)
        |=> count == $past(count) - ONE);
    // R3: zero is a resting state without a load or event
    a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !cmd.ld && !hit) |=> count == '0);
    // R3: the last tick raises the flag
    a_r3_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == ONE && !cmd.ld && !cmd.ctrl_wr && !hit) |=> status);
    // R5: an accepted event restarts from the stored value and clears the flag
    a_r5_event_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cmd.ld && !cmd.force_to) |=> count == $past(reload_val));
    a_r5_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cmd.ctrl_wr) |=> !status);
    // R9: force empties the counter and raises the flag
    a_r9_force: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.force_to |=> (count == '0 && status));
endmodule

// File: rtl/evwdt_top.sv
// Module: event-reloaded watchdog top. Ties together the register file,
// the event qualifier and the counter, and drives the interrupt, which
// follows the flag while a non-zero channel is stored.
// Assumes host writes and event pulses are synchronous to clk.
module evwdt_top
    import evwdt_pkg::*;
#(
    parameter int          CNT_W    = 8,
    parameter int          CHAN_W   = 4,
    parameter int          DATA_W   = 8,
    parameter int          ADDR_W   = 2,
    parameter int          IOA_W    = 16,
    parameter logic [15:0] JOY_ADDR = 16'h0201
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ev_kbd,
    input  logic              ev_mouse,
    input  logic              io_stb,
    input  logic [IOA_W-1:0]  io_addr,
    input  logic              hst_wr,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              wdt_status,
    output logic              wdt_irq
);
    logic [CNT_W-1:0]  reload_val, count;
    logic [NUM_EV-1:0] ev_en;
    logic [CHAN_W-1:0] chan;
    logic              hit;
    wr_cmd_t           cmd;

    evwdt_regs #(.CNT_W(CNT_W), .CHAN_W(CHAN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(hst_wr), .addr(hst_addr), .wdata(hst_wdata),
        .status(wdt_status), .count(count), .reload_val(reload_val), .ev_en(ev_en),
        .chan(chan), .cmd(cmd), .rdata(hst_rdata));

    evwdt_event #(.IOA_W(IOA_W), .JOY_ADDR(JOY_ADDR)) u_event (
        .kbd(ev_kbd), .mouse(ev_mouse), .io_stb(io_stb), .io_addr(io_addr),
        .en(ev_en), .hit(hit));

    evwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit), .cmd(cmd),
        .ld_val(hst_wdata[CNT_W-1:0]), .reload_val(reload_val),
        .count(count), .status(wdt_status));

    // Interrupt follows the flag while a channel is mapped
    assign wdt_irq = wdt_status && (chan != '0);

    // R10: the request is never raised without the flag
    a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq |-> wdt_status);
    // R10: a rising request comes only with a mapped channel
    a_r10_irq_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_irq) |-> (chan != '0));
endmodule

// File: tb/sim_evwdt_top.sv
// Bench: directed corner cases, then seeded random stimulus. All four
// registers and the interrupt are checked against a reference model
// after every cycle.
module sim_evwdt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 0, ev_kbd = 0, ev_mouse = 0, io_stb = 0, hst_wr = 0;
    logic [15:0] io_addr = '0;
    logic [1:0]  hst_addr = '0;
    logic [7:0]  hst_wdata = '0;
    logic [7:0]  hst_rdata;
    logic        wdt_status, wdt_irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Reference model state
    logic [7:0] m_cnt = 0, m_rel = 0;
    logic       m_stat = 0;
    logic [2:0] m_en = 0;
    logic [3:0] m_ch = 0;

    always #5 clk = ~clk;

    evwdt_top u0 (.*);

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_rel;
            2'd1: return {7'b0, m_stat};
            2'd2: return {m_ch, 1'b0, m_en};
            default: return m_cnt;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Read all registers and the interrupt, compare with the model
    task automatic check_all(input string tag);
        for (int a = 0; a < 4; a++) begin
            hst_wr = 0; hst_addr = 2'(a); #1;
            check($sformatf("%s reg%0d", tag, a), hst_rdata, exp_rd(2'(a)));
        end
        check({tag, " irq"}, {7'b0, wdt_irq}, {7'b0, m_stat && (m_ch != 0)});
    endtask

    // Apply one cycle of stimulus and advance the model
    task automatic step(input logic wr, input logic [1:0] a, input logic [7:0] d,
                        input logic tk, input logic kb, input logic ms,
                        input logic io, input logic [15:0] ioa);
        logic ev, ldw, cw;
        hst_wr = wr; hst_addr = a; hst_wdata = d; tick = tk;
        ev_kbd = kb; ev_mouse = ms; io_stb = io; io_addr = ioa;
        ev  = (kb && m_en[0]) || (ms && m_en[1]) || (io && ioa == 16'h0201 && m_en[2]);
        ldw = wr && a == 2'd0;
        cw  = wr && a == 2'd1;
        // flag first, using the old count
        if (cw)                                  m_stat = d[0] | d[2];
        else if (ev)                             m_stat = 0;
        else if (!ldw && tk && m_cnt == 8'd1)    m_stat = 1;
        if (ldw)                     m_cnt = d;
        else if (cw && d[2])         m_cnt = 0;
        else if (ev)                 m_cnt = m_rel;
        else if (tk && m_cnt != 0)   m_cnt = m_cnt - 1;
        if (ldw) m_rel = d;
        if (wr && a == 2'd2) begin m_en = d[2:0]; m_ch = d[7:4]; end
        @(posedge clk); #1;
        hst_wr = 0; tick = 0; ev_kbd = 0; ev_mouse = 0; io_stb = 0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        step(1, a, d, 0, 0, 0, 0, 16'h0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0, 0, 0, 16'h0);
    endtask

    // Watchdog: a hung run is a failure
    initial begin
        #1_500_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        check_all("R1");
        check("R1 status", {7'b0, wdt_status}, 8'h0);

        wr_reg(2, 8'h31);            check_all("R10 cfg kbd ch3");
        wr_reg(0, 8'd5);             check_all("R4 load");
        ticks(2);                    check_all("R2 decrement");
        step(0,0,0,0,1,0,0,16'h0);   check_all("R5 kbd reload");
        step(0,0,0,1,0,1,0,16'h0);   check_all("R6 mouse disabled");
        ticks(5);                    check_all("R3 expiry");
        check("R3 status pin", {7'b0, wdt_status}, 8'h1);
        ticks(3);                    check_all("R3 stays zero");
        wr_reg(2, 8'h32);
        step(0,0,0,0,0,1,0,16'h0);   check_all("R5 mouse reload clears");
        step(0,0,0,0,1,0,0,16'h0);   check_all("R6 kbd now disabled");
        ticks(5);
        step(0,0,0,0,1,0,0,16'h0);   check_all("R6 disabled keeps timeout");
        wr_reg(2, 8'h34);
        step(0,0,0,0,0,0,1,16'h0200); check_all("R7 other address");
        step(0,0,0,0,0,0,1,16'h0201); check_all("R7 game port reload");
        ticks(1);
        step(0,0,0,0,0,0,1,16'h0201); check_all("R7 reload after tick");
        wr_reg(1, 8'h01);            check_all("R8 set flag");
        wr_reg(1, 8'h00);            check_all("R8 clear flag");
        wr_reg(1, 8'h04);            check_all("R9 force");
        wr_reg(2, 8'h04);            check_all("R10 unmapped");
        check("R10 irq low", {7'b0, wdt_irq}, 8'h0);
        wr_reg(2, 8'h94);            check_all("R10 remapped");
        step(1,1,8'h01,0,0,0,1,16'h0201); check_all("R11 ctrl beats event");
        step(1,0,8'd9,0,0,0,1,16'h0201);  check_all("R11 reload beats event");
        wr_reg(1, 8'h00);
        wr_reg(0, 8'd0);             check_all("R12 zero reload");
        ticks(4);                    check_all("R12 no expiry");

        // Random phase
        for (int i = 0; i < 1500; i++) begin
            logic w;
            logic [1:0] a;
            logic [7:0] d;
            w = ($urandom % 6) == 0;
            a = 2'($urandom);
            d = 8'($urandom);
            if (a == 2'd0) d = 8'($urandom % 12);
            step(w, a, d, $urandom % 2 == 0, $urandom % 9 == 0, $urandom % 9 == 0,
                 $urandom % 7 == 0, ($urandom % 2 == 0) ? 16'h0201 : 16'($urandom));
            check_all("R2 R3 R5 R7 R11 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule